// File: doc/BRIEF.md
# Threshold-Driven DMA Request Byte FIFO

This block is a byte FIFO placed between a DMA data port and a serial engine. It can serve either direction. It tells the DMA controller when to move data by raising a request line based on how full it is. On the transmit side the request stays high while the FIFO is low enough to take more bytes. On the receive side it stays high while there is enough data to drain.

Two sizing modes are available:
- **Compatibility mode:** holds 32 bytes and requests at a fixed level of 16.
- **Normal mode:** holds 96 bytes and requests at a level set by configuration.

On the transmit side, an optional hold-back keeps the first byte from leaving until the fill has reached the threshold. The FIFO also remembers where the current frame began. After a collision it can replay that frame from bytes it still holds, as long as none of them has been overwritten.

A fill state machine gates the read side. It has three states:
- **EMPTY:** no bytes are stored.
- **HOLD:** bytes are present but the transmit hold-back keeps them in.
- **RUN:** bytes may be read.

Its transitions are:
- **EMPTY→RUN** or **EMPTY→HOLD:** taken on the first stored byte, depending on whether the hold-back gate is satisfied.
- **HOLD→RUN:** taken when the gate opens.
- **RUN→EMPTY** and **HOLD→EMPTY:** taken when the fill returns to zero.

Top module: `thr_dma_fifo`

## Requirements
- R1: After reset the fill level is 0, `pop_valid` and `overflow` are low, and the settings are: normal mode, transmit side, hold-back off, threshold 48. `dma_req` is therefore high.
- R2: Bytes leave through `pop_data` in the order they were accepted. A byte is accepted on a clock edge where `push_valid` is high and the FIFO is not full. A byte is read on an edge where `pop_ready` and `pop_valid` are high and `collision` is low.
- R3: With `cfg_compat`=1 the FIFO holds at most 32 bytes and the request threshold is 16, whatever `cfg_thresh` holds.
- R4: With `cfg_compat`=0 the FIFO holds at most 96 bytes and the request threshold is `cfg_thresh`.
- R5: On the transmit side (`cfg_rx`=0), `dma_req` is high exactly while the fill level is less than or equal to the threshold.
- R6: On the receive side (`cfg_rx`=1), `dma_req` is high exactly while the fill level is greater than or equal to the threshold.
- R7: With hold-back on (`cfg_hold`=1, transmit side), `pop_valid` stays low until the fill reaches the threshold. Once high, it stays high until the FIFO empties.
- R8: A `frame_start` pulse marks the next byte to be read as the frame's first byte. A later `collision` pulse rewinds reading to that byte, adds the bytes already read back into the fill level, and the frame is read again in order.
- R9: A collision has no effect in compatibility mode. It also has no effect once a byte of the marked frame has been overwritten by a new push. In both cases the fill level and the data order are unchanged.
- R10: A push while full is dropped and sets `overflow`, which stays high until reset.
- R11: A `cfg_load` pulse takes the new settings only when the fill level is 0. Otherwise it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load new settings (taken only when empty) |
| cfg_compat | input | 1 | 1 = 32-byte compatibility mode |
| cfg_rx | input | 1 | 1 = receive side, 0 = transmit side |
| cfg_hold | input | 1 | Transmit hold-back until threshold |
| cfg_thresh | input | 7 | Request threshold for normal mode |
| push_valid | input | 1 | Byte offered on `push_data` |
| push_data | input | 8 | Incoming byte |
| pop_ready | input | 1 | Reader takes the byte on `pop_data` |
| pop_data | output | 8 | Byte at the read position |
| pop_valid | output | 1 | A byte may be read (state RUN) |
| frame_start | input | 1 | Mark the read position as frame start |
| collision | input | 1 | Rewind to the marked frame start |
| dma_req | output | 1 | DMA service request |
| level | output | 7 | Current fill level |
| overflow | output | 1 | Sticky dropped-push flag |

## Verification
The properties assume several things about the inputs:
- `cfg_load` is pulsed only when no settings change is wanted in mid-stream.
- `frame_start` and `collision` are never raised in the same cycle.
- `pop_ready` is never raised while a collision is being signalled.

The stimulus drives every control as a one-cycle pulse separated by idle cycles, so these conditions always hold. Each pulse is changed on the falling edge, and settings are only reloaded after the FIFO has been drained to zero.

// File: rtl/tdf_pkg.sv
package tdf_pkg;
    localparam int DEPTH_MAX    = 96;
    localparam int DEPTH_COMPAT = 32;
    localparam int THR_COMPAT   = 16;
    localparam int LVL_W        = $clog2(DEPTH_MAX + 1);
    localparam int PTR_W        = $clog2(DEPTH_MAX);

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_HOLD  = 2'd1,
        ST_RUN   = 2'd2
    } fill_state_e;

    typedef struct packed {
        logic             compat;
        logic             rx_side;
        logic             hold_tx;
        logic [LVL_W-1:0] thresh;
    } fifo_cfg_t;
endpackage

// File: rtl/tdf_cfg_reg.sv
module tdf_cfg_reg
    import tdf_pkg::*;
#(
    parameter int DEF_THRESH = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             fifo_empty,
    input  fifo_cfg_t        cfg_in,
    output fifo_cfg_t        cfg_q,
    output logic [LVL_W-1:0] depth,
    output logic [LVL_W-1:0] thr_eff,
    output logic             applied
);
    assign applied = load && fifo_empty;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.compat  <= 1'b0;
            cfg_q.rx_side <= 1'b0;
            cfg_q.hold_tx <= 1'b0;
            cfg_q.thresh  <= LVL_W'(DEF_THRESH);
        end else if (applied) begin
            cfg_q <= cfg_in;
        end
    end

    always_comb begin
        if (cfg_q.compat) begin
            depth   = LVL_W'(DEPTH_COMPAT);
            thr_eff = LVL_W'(THR_COMPAT);
        end else begin
            depth   = LVL_W'(DEPTH_MAX);
            thr_eff = cfg_q.thresh;
        end
    end
endmodule

// File: rtl/tdf_store.sv
module tdf_store
    import tdf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH_MAX];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/tdf_fill_fsm.sv
module tdf_fill_fsm
    import tdf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] lvl_next,
    input  logic             gate_ok,
    output fill_state_e      state,
    output logic             may_pop
);
    fill_state_e state_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_EMPTY;
        end else begin
            state <= state_n;
        end
    end

    always_comb begin
        state_n = state;
        unique case (state)
            ST_EMPTY: begin
                if (lvl_next != '0) begin
                    state_n = gate_ok ? ST_RUN : ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (lvl_next == '0) begin
                    state_n = ST_EMPTY;
                end else if (gate_ok) begin
                    state_n = ST_RUN;
                end
            end
            ST_RUN: begin
                if (lvl_next == '0) begin
                    state_n = ST_EMPTY;
                end
            end
            default: state_n = ST_EMPTY;
        endcase
    end

    always_comb begin
        may_pop = (state == ST_RUN);
    end
endmodule

// File: rtl/thr_dma_fifo.sv
module thr_dma_fifo
    import tdf_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int DEF_THRESH = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic              cfg_compat,
    input  logic              cfg_rx,
    input  logic              cfg_hold,
    input  logic [LVL_W-1:0]  cfg_thresh,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_ready,
    output logic [DATA_W-1:0] pop_data,
    output logic              pop_valid,
    input  logic              frame_start,
    input  logic              collision,
    output logic              dma_req,
    output logic [LVL_W-1:0]  level,
    output logic              overflow
);
    fifo_cfg_t        cfg_in, cfg_q;
    logic [LVL_W-1:0] depth, thr_eff;
    logic             applied;

    logic [PTR_W-1:0] wr_ptr, rd_ptr, frm_ptr, wa;
    logic [LVL_W-1:0] count, held, cnt_n;
    logic [LVL_W:0]   occupied;
    logic             frame_ok, ovf_q;
    logic             push_ok, pop_ok, overwrite, rewind, gate_ok, may_pop;
    fill_state_e      state;

    assign cfg_in = '{compat: cfg_compat, rx_side: cfg_rx, hold_tx: cfg_hold, thresh: cfg_thresh};

    tdf_cfg_reg #(.DEF_THRESH(DEF_THRESH)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (cfg_load),
        .fifo_empty (count == '0),
        .cfg_in     (cfg_in),
        .cfg_q      (cfg_q),
        .depth      (depth),
        .thr_eff    (thr_eff),
        .applied    (applied)
    );

    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p,
                                                  input logic [LVL_W-1:0] d);
        return (p == PTR_W'(d - 1'b1)) ? '0 : p + 1'b1;
    endfunction

    assign occupied  = {1'b0, count} + {1'b0, held};
    assign push_ok   = push_valid && (count != depth);
    assign overwrite = push_ok && frame_ok && !applied && (occupied == {1'b0, depth});
    assign pop_ok    = pop_ready && may_pop && !collision;
    assign rewind    = collision && frame_ok && !cfg_q.compat && !overwrite
                       && !applied && !frame_start;
    assign wa        = applied ? '0 : wr_ptr;

    always_comb begin
        cnt_n = count;
        if (push_ok) cnt_n = cnt_n + 1'b1;
        if (pop_ok)  cnt_n = cnt_n - 1'b1;
        if (rewind)  cnt_n = cnt_n + held;
    end

    assign gate_ok = cfg_q.rx_side || !cfg_q.hold_tx || (cnt_n >= thr_eff);

    tdf_fill_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_next (cnt_n),
        .gate_ok  (gate_ok),
        .state    (state),
        .may_pop  (may_pop)
    );

    tdf_store #(.DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .we    (push_ok),
        .waddr (wa),
        .wdata (push_data),
        .raddr (rd_ptr),
        .rdata (pop_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            frm_ptr  <= '0;
            count    <= '0;
            held     <= '0;
            frame_ok <= 1'b0;
            ovf_q    <= 1'b0;
        end else begin
            count <= cnt_n;
            if (push_valid && !push_ok) ovf_q <= 1'b1;

            if (push_ok)      wr_ptr <= step_ptr(wa, depth);
            else if (applied) wr_ptr <= '0;

            if (applied)     rd_ptr <= '0;
            else if (rewind) rd_ptr <= frm_ptr;
            else if (pop_ok) rd_ptr <= step_ptr(rd_ptr, depth);

            if (applied) begin
                frame_ok <= 1'b0;
                held     <= '0;
            end else if (frame_start) begin
                frame_ok <= 1'b1;
                frm_ptr  <= rd_ptr;
                held     <= pop_ok ? LVL_W'(1) : '0;
            end else if (overwrite) begin
                frame_ok <= 1'b0;
                held     <= '0;
            end else if (rewind) begin
                held     <= '0;
            end else if (frame_ok && pop_ok) begin
                held     <= held + 1'b1;
            end
        end
    end

    assign pop_valid = may_pop;
    assign level     = count;
    assign overflow  = ovf_q;
    assign dma_req   = cfg_q.rx_side ? (count >= thr_eff) : (count <= thr_eff);
endmodule

// File: rtl/thr_dma_fifo_chk.sv
module thr_dma_fifo_chk
    import tdf_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [LVL_W-1:0] level,
    input logic             overflow,
    input logic             pop_valid,
    input logic             cfg_load,
    input fifo_cfg_t        cfg_q,
    input logic [LVL_W-1:0] thr_eff
);
    // R10
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R3
    compat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.compat |-> (level <= LVL_W'(DEPTH_COMPAT)));

    // R4
    full_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH_MAX));

    // R7
    hold_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.rx_side && cfg_q.hold_tx && $rose(pop_valid)) |-> (level >= thr_eff));

    // R11
    cfg_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && level != '0) |=> $stable(cfg_q));

    // R7
    run_until_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_valid && level > LVL_W'(1)) |=> pop_valid);
endmodule

bind thr_dma_fifo thr_dma_fifo_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .level     (level),
    .overflow  (overflow),
    .pop_valid (pop_valid),
    .cfg_load  (cfg_load),
    .cfg_q     (cfg_q),
    .thr_eff   (thr_eff)
);

// File: tb/thr_dma_fifo_test.sv
module thr_dma_fifo_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_load = 1'b0, cfg_compat = 1'b0, cfg_rx = 1'b0, cfg_hold = 1'b0;
    logic [6:0] cfg_thresh = '0;
    logic       push_valid = 1'b0;
    logic [7:0] push_data = '0;
    logic       pop_ready = 1'b0;
    logic [7:0] pop_data;
    logic       pop_valid;
    logic       frame_start = 1'b0, collision = 1'b0;
    logic       dma_req;
    logic [6:0] level;
    logic       overflow;

    byte unsigned q[$];
    byte unsigned sent[$];
    int           exp_lvl = 0;
    int           cur_depth = 96;
    int           n_chk = 0;
    int           n_fail = 0;
    logic [7:0]   nb = 8'h10;

    always #10 clk = ~clk;

    thr_dma_fifo uut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_compat(cfg_compat),
        .cfg_rx(cfg_rx), .cfg_hold(cfg_hold), .cfg_thresh(cfg_thresh),
        .push_valid(push_valid), .push_data(push_data), .pop_ready(pop_ready),
        .pop_data(pop_data), .pop_valid(pop_valid), .frame_start(frame_start),
        .collision(collision), .dma_req(dma_req), .level(level), .overflow(overflow)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: scoreboard pop side, samples 2 ns before the rising edge
    always begin
        @(negedge clk);
        #8;
        if (rst_n && pop_ready && !collision) begin
            check(pop_valid == 1'b1, "R2 pop_valid", int'(pop_valid), 1);
            if (q.size() == 0) begin
                check(1'b0, "R2 unexpected pop", int'(pop_data), -1);
            end else begin
                check(pop_data == q[0], "R2 data order", int'(pop_data), int'(q[0]));
                if (frame_start) sent.delete();
                sent.push_back(q[0]);
                void'(q.pop_front());
                exp_lvl--;
            end
        end
    end

    task automatic push1();
        @(negedge clk);
        push_valid = 1'b1;
        push_data  = nb;
        if (exp_lvl < cur_depth) begin
            q.push_back(nb);
            exp_lvl++;
        end
        nb = nb + 8'd1;
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    task automatic pop1(input bit mark);
        @(negedge clk);
        pop_ready   = 1'b1;
        frame_start = mark;
        @(negedge clk);
        pop_ready   = 1'b0;
        frame_start = 1'b0;
    endtask

    task automatic collide(input bit replay);
        @(negedge clk);
        collision = 1'b1;
        if (replay) begin
            for (int i = sent.size() - 1; i >= 0; i--) q.push_front(sent[i]);
            exp_lvl += sent.size();
        end
        sent.delete();
        @(negedge clk);
        collision = 1'b0;
    endtask

    task automatic setcfg(input bit c, input bit r, input bit h, input int t);
        @(negedge clk);
        cfg_load = 1'b1; cfg_compat = c; cfg_rx = r; cfg_hold = h; cfg_thresh = 7'(t);
        if (exp_lvl == 0) cur_depth = c ? 32 : 96;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic drain(input string req);
        while (q.size() > 0) pop1(1'b0);
        check(level == 0, req, int'(level), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(level == 0, "R1 level", int'(level), 0);
        check(pop_valid == 0, "R1 pop_valid", int'(pop_valid), 0);
        check(overflow == 0, "R1 overflow", int'(overflow), 0);
        check(dma_req == 1, "R1 dma_req", int'(dma_req), 1);

        // R5 transmit threshold
        setcfg(0, 0, 0, 4);
        repeat (3) push1();
        check(pop_valid == 1, "R7 no hold", int'(pop_valid), 1);
        check(dma_req == 1, "R5 below thr", int'(dma_req), 1);
        push1();
        check(dma_req == 1, "R5 at thr", int'(dma_req), 1);
        push1();
        check(dma_req == 0, "R5 above thr", int'(dma_req), 0);
        drain("R2 drained");

        // R11 settings ignored while not empty
        push1();
        setcfg(0, 1, 0, 10);
        check(dma_req == 1, "R11 cfg ignored", int'(dma_req), 1);
        drain("R11 drained");

        // R6 receive threshold
        setcfg(0, 1, 0, 3);
        check(dma_req == 0, "R6 empty", int'(dma_req), 0);
        repeat (2) push1();
        check(dma_req == 0, "R6 below thr", int'(dma_req), 0);
        push1();
        check(dma_req == 1, "R6 at thr", int'(dma_req), 1);
        drain("R6 drained");

        // R7 transmit hold-back
        setcfg(0, 0, 1, 4);
        repeat (3) push1();
        check(pop_valid == 0, "R7 held", int'(pop_valid), 0);
        push1();
        check(pop_valid == 1, "R7 released", int'(pop_valid), 1);
        repeat (3) pop1(1'b0);
        check(pop_valid == 1, "R7 stays running", int'(pop_valid), 1);
        drain("R7 drained");

        // R3 compatibility mode, R10 overflow, R9 no replay in compat
        setcfg(1, 0, 0, 50);
        for (int i = 1; i <= 33; i++) begin
            push1();
            if (i == 16) check(dma_req == 1, "R3 thr 16", int'(dma_req), 1);
            if (i == 17) check(dma_req == 0, "R3 over 16", int'(dma_req), 0);
        end
        check(level == 32, "R3 depth 32", int'(level), 32);
        check(overflow == 1, "R10 overflow set", int'(overflow), 1);
        pop1(1'b1);
        pop1(1'b0);
        collide(1'b0);
        check(level == 30, "R9 compat no replay", int'(level), 30);
        drain("R9 compat drained");
        check(overflow == 1, "R10 sticky", int'(overflow), 1);

        // R4 normal mode depth and programmed threshold
        setcfg(0, 0, 0, 90);
        for (int i = 1; i <= 97; i++) begin
            push1();
            if (i == 90) check(dma_req == 1, "R4 at thr 90", int'(dma_req), 1);
            if (i == 91) check(dma_req == 0, "R4 over thr 90", int'(dma_req), 0);
        end
        check(level == 96, "R4 depth 96", int'(level), 96);
        drain("R4 drained");

        // R8 replay after collision
        setcfg(0, 0, 0, 8);
        repeat (6) push1();
        pop1(1'b1);
        repeat (2) pop1(1'b0);
        check(level == 3, "R8 before collision", int'(level), 3);
        collide(1'b1);
        check(level == 6, "R8 rewound level", int'(level), 6);
        drain("R8 replayed");

        // R9 replay refused after overwrite
        repeat (90) push1();
        pop1(1'b1);
        repeat (9) pop1(1'b0);
        repeat (16) push1();
        check(level == 96, "R9 full", int'(level), 96);
        collide(1'b0);
        check(level == 96, "R9 overwritten no replay", int'(level), 96);
        drain("R9 drained");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule